// File: doc/BRIEF.md
# FIFO Level Interrupt and DMA Request Generator

This block sits beside a 16-entry serial-port FIFO pair. It turns the FIFO occupancy into service requests. It watches four inputs: the number of free transmit entries, the number of filled receive entries, an indication that the transmit shifter has gone quiet, and an indication that the receive shifter holds a finished word. From these it drives four status flags, two DMA request lines and one combined interrupt line.

The two threshold flags are levels. "Transmit room" is active while the free space is at least a programmable transmit threshold. "Receive ready" is active while the fill count is at least a programmable receive threshold. Each of these also drives a DMA request directly. The "transfer done" flag and the "overrun" flag are events held until software clears them with a write-one-to-clear pulse. Each flag has an enable bit, and the interrupt line combines the enabled flags. Both thresholds are one bit wider than the FIFO index, so every level from 0 up to the full depth can be programmed.

Top module: `fifo_irq_trigger`

## Requirements
- R1: flags[0] (transmit room) is 1 in the cycle after a clock edge at which txSpace >= txThreshold was sampled, and 0 otherwise.
- R2: flags[1] (receive ready) is 1 in the cycle after a clock edge at which rxCount >= rxThreshold was sampled, and 0 otherwise.
- R3: flags[2] (transfer done) is set one edge after txSpace == DEPTH and shifterIdle both become true, where they were not both true at the previous edge. It is never set while that condition merely persists, including the idle state right after reset.
- R4: flags[3] (overrun) is set at every edge where rxCount == DEPTH and rxShifterFull are both sampled high.
- R5: flags[2] and flags[3] hold their value until cleared: clrSticky[0] clears flags[2] and clrSticky[1] clears flags[3], one edge after the pulse.
- R6: if a set condition and the matching clear bit occur at the same edge, the flag ends up set.
- R7: txDmaReq always equals flags[0] and rxDmaReq always equals flags[1], whatever intEnable holds.
- R8: irq is the OR over i of flags[i] AND intEnable[i], using bit order 0 room, 1 ready, 2 done, 3 overrun. It follows intEnable in the same cycle, with no extra register.
- R9: while rstN is low, all flags, both DMA requests and irq are 0.
- R10: a threshold of 0 keeps its flag at 1 for every count. A threshold above DEPTH (17 to 31) keeps its flag at 0 for every count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txSpace | input | 5 | Free entries in the transmit FIFO, 0..DEPTH |
| rxCount | input | 5 | Filled entries in the receive FIFO, 0..DEPTH |
| shifterIdle | input | 1 | Transmit shifter has sent its last bit and is empty |
| rxShifterFull | input | 1 | Receive shifter holds a complete word it cannot store |
| txThreshold | input | 5 | Free-space level that raises transmit room |
| rxThreshold | input | 5 | Fill level that raises receive ready |
| intEnable | input | 4 | Per-flag interrupt enable, same bit order as flags |
| clrSticky | input | 2 | Write-one-to-clear pulses: bit 0 done, bit 1 overrun |
| flags | output | 4 | Status flags: 0 room, 1 ready, 2 done, 3 overrun |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench walks each count across its threshold, checking the values one below, equal to and one above it. A comparator off by one, or one that uses strict greater-than, shows up as a flag one step late. Thresholds of 0, 17 and 31 are also applied: a comparison truncated to four bits would wrap 17 to 1 and raise the flag wrongly. Two cases target a done flag driven as a level instead of an edge: the reset idle state, and a clear issued while the FIFO stays empty. Such a design would raise the flag immediately after reset or bring it back after the clear. Clear and set are also applied together at one edge, to catch a design that gives clear the priority and so loses an overrun or completion. Interrupt enables are cleared while DMA requests are pending, to catch any design that masks the DMA lines through the interrupt enables.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  localparam int FLAG_ROOM  = 0;
  localparam int FLAG_READY = 1;
  localparam int FLAG_DONE  = 2;
  localparam int FLAG_OVR   = 3;
  localparam int NUM_FLAGS  = 4;

  localparam int CLR_DONE = 0;
  localparam int CLR_OVR  = 1;
  localparam int NUM_CLR  = 2;

  // Event strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic doneSet;
    logic doneClr;
    logic ovrSet;
    logic ovrClr;
  } flagStrobeT;

endpackage

// File: rtl/fifo_irq_cmp.sv
module fifo_irq_cmp #(
  parameter int W = 5
) (
  input  logic [W-1:0] level,
  input  logic [W-1:0] limit,
  output logic         hit
);

  // Unsigned compare over the full width, so limits above the depth never hit
  always_comb begin
    hit = (level >= limit);
  end

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   txSpace,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic               shifterIdle,
  input  logic               rxShifterFull,
  input  logic [NUM_CLR-1:0] clrSticky,
  output flagStrobeT         strobe
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic doneNow;
  logic donePrev;
  logic ovrNow;

  always_comb begin
    doneNow = (txSpace == FULL_LVL) && shifterIdle;
    ovrNow  = (rxCount == FULL_LVL) && rxShifterFull;
  end

  // Starts high so the idle state after reset is not a completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      donePrev <= 1'b1;
    end else begin
      donePrev <= doneNow;
    end
  end

  always_comb begin
    strobe.doneSet = doneNow && !donePrev;
    strobe.doneClr = clrSticky[CLR_DONE];
    strobe.ovrSet  = ovrNow;
    strobe.ovrClr  = clrSticky[CLR_OVR];
  end

endmodule

// File: rtl/fifo_irq_datapath.sv
module fifo_irq_datapath
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     txSpace,
  input  logic [CNT_W-1:0]     rxCount,
  input  logic [CNT_W-1:0]     txThreshold,
  input  logic [CNT_W-1:0]     rxThreshold,
  input  logic [NUM_FLAGS-1:0] intEnable,
  input  flagStrobeT           strobe,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);

  logic roomHit;
  logic readyHit;
  logic roomQ;
  logic readyQ;
  logic doneQ;
  logic ovrQ;
  logic [NUM_FLAGS-1:0] masked;

  fifo_irq_cmp #(.W(CNT_W)) u_roomCmp (
    .level (txSpace),
    .limit (txThreshold),
    .hit   (roomHit)
  );

  fifo_irq_cmp #(.W(CNT_W)) u_readyCmp (
    .level (rxCount),
    .limit (rxThreshold),
    .hit   (readyHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roomQ  <= 1'b0;
      readyQ <= 1'b0;
    end else begin
      roomQ  <= roomHit;
      readyQ <= readyHit;
    end
  end

  // Sticky flags: a set at the same edge wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      ovrQ  <= 1'b0;
    end else begin
      if (strobe.doneSet)      doneQ <= 1'b1;
      else if (strobe.doneClr) doneQ <= 1'b0;
      if (strobe.ovrSet)       ovrQ  <= 1'b1;
      else if (strobe.ovrClr)  ovrQ  <= 1'b0;
    end
  end

  always_comb begin
    flags             = '0;
    flags[FLAG_ROOM]  = roomQ;
    flags[FLAG_READY] = readyQ;
    flags[FLAG_DONE]  = doneQ;
    flags[FLAG_OVR]   = ovrQ;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_mask
    assign masked[g] = flags[g] & intEnable[g];
  end

  assign irq = |masked;

endmodule

// File: rtl/fifo_irq_trigger.sv
module fifo_irq_trigger
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     txSpace,
  input  logic [CNT_W-1:0]     rxCount,
  input  logic                 shifterIdle,
  input  logic                 rxShifterFull,
  input  logic [CNT_W-1:0]     txThreshold,
  input  logic [CNT_W-1:0]     rxThreshold,
  input  logic [NUM_FLAGS-1:0] intEnable,
  input  logic [NUM_CLR-1:0]   clrSticky,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 txDmaReq,
  output logic                 rxDmaReq,
  output logic                 irq
);

  flagStrobeT strobe;

  fifo_irq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .txSpace       (txSpace),
    .rxCount       (rxCount),
    .shifterIdle   (shifterIdle),
    .rxShifterFull (rxShifterFull),
    .clrSticky     (clrSticky),
    .strobe        (strobe)
  );

  fifo_irq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .txSpace     (txSpace),
    .rxCount     (rxCount),
    .txThreshold (txThreshold),
    .rxThreshold (rxThreshold),
    .intEnable   (intEnable),
    .strobe      (strobe),
    .flags       (flags),
    .irq         (irq)
  );

  // DMA lines bypass the interrupt enables
  assign txDmaReq = flags[FLAG_ROOM];
  assign rxDmaReq = flags[FLAG_READY];

endmodule

// File: rtl/fifo_irq_checker.sv
module fifo_irq_checker
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [CNT_W-1:0]     txSpace,
  input logic [CNT_W-1:0]     rxCount,
  input logic                 shifterIdle,
  input logic                 rxShifterFull,
  input logic [CNT_W-1:0]     txThreshold,
  input logic [CNT_W-1:0]     rxThreshold,
  input logic [NUM_CLR-1:0]   clrSticky,
  input logic [NUM_FLAGS-1:0] flags
);

  logic pastValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r1_room_level: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> flags[FLAG_ROOM] == ($past(txSpace) >= $past(txThreshold)));

  a_r2_ready_level: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> flags[FLAG_READY] == ($past(rxCount) >= $past(rxThreshold)));

  a_r3_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(flags[FLAG_DONE]))
      |-> $past(txSpace == CNT_W'(DEPTH) && shifterIdle));

  a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(rxCount == CNT_W'(DEPTH) && rxShifterFull))
      |-> flags[FLAG_OVR]);

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(flags[FLAG_DONE]) && !$past(clrSticky[CLR_DONE]))
      |-> flags[FLAG_DONE]);

endmodule

bind fifo_irq_trigger fifo_irq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .txSpace       (txSpace),
  .rxCount       (rxCount),
  .shifterIdle   (shifterIdle),
  .rxShifterFull (rxShifterFull),
  .txThreshold   (txThreshold),
  .rxThreshold   (rxThreshold),
  .clrSticky     (clrSticky),
  .flags         (flags)
);

// File: tb/fifo_irq_trigger_tb.sv
`timescale 1ns/1ps
module fifo_irq_trigger_tb;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] txSpace = '0;
  logic [4:0] rxCount = '0;
  logic       shifterIdle = 1'b0;
  logic       rxShifterFull = 1'b0;
  logic [4:0] txThreshold = '0;
  logic [4:0] rxThreshold = '0;
  logic [3:0] intEnable = '0;
  logic [1:0] clrSticky = '0;
  logic [3:0] flags;
  logic       txDmaReq;
  logic       rxDmaReq;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  bit mRoom, mReady, mDone, mOvr;
  bit mPrevDone = 1;

  always #2 clk = ~clk;

  fifo_irq_trigger #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .txSpace(txSpace), .rxCount(rxCount),
    .shifterIdle(shifterIdle), .rxShifterFull(rxShifterFull),
    .txThreshold(txThreshold), .rxThreshold(rxThreshold),
    .intEnable(intEnable), .clrSticky(clrSticky),
    .flags(flags), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string ctx,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) at %0t: actual=%0h expected=%0h", req, ctx, $time, act, exp);
    end
  endtask

  task automatic modelStep();
    bit doneNow, ovrNow;
    doneNow = (int'(txSpace) == DEPTH) && shifterIdle;
    ovrNow  = (int'(rxCount) == DEPTH) && rxShifterFull;
    if (doneNow && !mPrevDone) mDone = 1;
    else if (clrSticky[0])     mDone = 0;
    if (ovrNow)                mOvr = 1;
    else if (clrSticky[1])     mOvr = 0;
    mPrevDone = doneNow;
    mRoom  = int'(txSpace) >= int'(txThreshold);
    mReady = int'(rxCount) >= int'(rxThreshold);
  endtask

  task automatic compareAll(input string ctx);
    bit [3:0] exp;
    exp = {mOvr, mDone, mReady, mRoom};
    check(flags[0] === exp[0], "R1", ctx, flags[0], exp[0]);
    check(flags[1] === exp[1], "R2", ctx, flags[1], exp[1]);
    check(flags[2] === exp[2], "R3", ctx, flags[2], exp[2]);
    check(flags[3] === exp[3], "R4", ctx, flags[3], exp[3]);
    check(txDmaReq === exp[0] && rxDmaReq === exp[1], "R7", ctx,
          {txDmaReq, rxDmaReq}, {exp[0], exp[1]});
    check(irq === |(exp & intEnable), "R8", ctx, irq, |(exp & intEnable));
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge
  task automatic tick(input string ctx);
    @(posedge clk);
    if (rstN) modelStep();
    @(negedge clk);
    compareAll(ctx);
  endtask

  task automatic drive(input int tx, input int rx, input bit idle, input bit shf,
                       input int txT, input int rxT, input bit [3:0] en,
                       input bit [1:0] clr, input string ctx);
    txSpace = 5'(tx); rxCount = 5'(rx); shifterIdle = idle; rxShifterFull = shf;
    txThreshold = 5'(txT); rxThreshold = 5'(rxT); intEnable = en; clrSticky = clr;
    tick(ctx);
    clrSticky = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset holds every output low, even with conditions that would set flags
    txSpace = 5'd16; shifterIdle = 1; rxCount = 5'd16; rxShifterFull = 1;
    intEnable = 4'hF;
    repeat (3) begin
      @(negedge clk);
      check(flags === 4'b0 && !txDmaReq && !rxDmaReq && !irq, "R9", "reset",
            {flags, txDmaReq, rxDmaReq, irq}, 0);
    end
    rxShifterFull = 0; rxCount = 0;
    rstN = 1;

    // R3: empty and idle straight after reset is not a completion
    for (int i = 0; i < 4; i++) drive(16, 0, 1, 0, 4, 4, 4'hF, 2'b00, "R3 idle after reset");

    // R1: sweep free space across threshold 8
    for (int s = 0; s <= DEPTH; s++) drive(s, 0, 0, 0, 8, 20, 4'h1, 2'b00, "R1 sweep");
    for (int s = DEPTH; s >= 0; s--) drive(s, 0, 0, 0, 7, 20, 4'h1, 2'b00, "R1 down");

    // R2: sweep fill count across threshold 5
    for (int s = 0; s <= DEPTH; s++) drive(10, s, 0, 0, 20, 5, 4'h2, 2'b00, "R2 sweep");

    // R10: zero threshold always on, above-depth thresholds never on
    for (int s = 0; s <= DEPTH; s += 4) drive(s, s, 0, 0, 0, 0, 4'h3, 2'b00, "R10 zero");
    drive(16, 16, 0, 0, 17, 17, 4'h3, 2'b00, "R10 seventeen");
    drive(16, 16, 0, 0, 31, 31, 4'h3, 2'b00, "R10 max");
    drive(0, 0, 0, 0, 0, 31, 4'h3, 2'b00, "R10 mix");

    // R3: transfer completes when last word leaves and shifter goes idle
    drive(10, 0, 0, 0, 4, 4, 4'h4, 2'b00, "R3 busy");
    drive(16, 0, 0, 0, 4, 4, 4'h4, 2'b00, "R3 empty still shifting");
    drive(16, 0, 1, 0, 4, 4, 4'h4, 2'b00, "R3 completion");
    drive(16, 0, 1, 0, 4, 4, 4'h4, 2'b00, "R3 held");
    // R5: clear while condition persists leaves it cleared
    drive(16, 0, 1, 0, 4, 4, 4'h4, 2'b01, "R5 clear done");
    drive(16, 0, 1, 0, 4, 4, 4'h4, 2'b00, "R5 stays clear");
    // R6: new completion with a simultaneous clear stays set
    drive(15, 0, 0, 0, 4, 4, 4'h4, 2'b00, "R6 new word");
    drive(16, 0, 1, 0, 4, 4, 4'h4, 2'b01, "R6 set beats clear");
    drive(16, 0, 1, 0, 4, 4, 4'h4, 2'b00, "R6 after");

    // R4: overrun when receive FIFO and shifter are both full
    drive(16, 15, 1, 1, 4, 4, 4'h8, 2'b00, "R4 not full yet");
    drive(16, 16, 1, 1, 4, 4, 4'h8, 2'b00, "R4 overrun");
    drive(16, 16, 1, 1, 4, 4, 4'h8, 2'b10, "R6 clear during overrun");
    drive(16, 12, 1, 0, 4, 4, 4'h8, 2'b00, "R5 sticky after drain");
    drive(16, 12, 1, 0, 4, 4, 4'h8, 2'b01, "R5 wrong clear bit");
    drive(16, 12, 1, 0, 4, 4, 4'h8, 2'b10, "R5 clear overrun");
    drive(16, 12, 1, 0, 4, 4, 4'h8, 2'b00, "R5 overrun gone");

    // R7/R8: enables do not gate DMA; irq tracks enables combinationally
    for (int e = 0; e < 16; e++) drive(16, 16, 1, 0, 2, 2, 4'(e), 2'b00, "R8 enable walk");
    drive(16, 16, 1, 0, 2, 2, 4'h0, 2'b00, "R7 enables off");
    intEnable = 4'h1;
    #1;
    check(irq === mRoom, "R8", "enable same cycle", irq, mRoom);

    // Mixed random traffic
    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(12, 16), $urandom_range(12, 16), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), $urandom_range(0, 18), $urandom_range(0, 18),
            4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), "random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule